// File: doc/BRIEF.md
# Word-Clock Framing Guard with Interrupt Flags

This block watches the word-clock edges of a serial audio port and decides, from where each edge falls inside the current phase, whether the frame timing has been broken. It counts bit-clock ticks from the last accepted word-clock edge. It tracks the delay window before the first data bit, the bit position inside each word and the channel slot reached. An edge that falls where no edge may fall raises a framing error. After a framing error the guard accepts the next edge without checking it, and checks again from there on. A second counter, run on the system clock, flags a word clock that has gone silent.

The framing error, the silence timeout and four event inputs feed a six-bit flag register. The event inputs are pointer error, bus error, output-buffer done and input-buffer done. Software can set or clear any flag. The two buffer-done flags also clear themselves when their next-pointer register is written. A single interrupt line is the registered OR of the flags that the mask enables.

Top module: `wclk_guard`

## Requirements
- R1: After reset all six flags read 0, the interrupt line is low, and the first word-clock edge is accepted without a check.
- R2: An edge that comes fewer than `data_delay` bit-clock ticks after the previous accepted edge sets flag bit 1 (word-clock error).
- R3: With `dual_phase` high, an edge that comes fewer than 4 bit-clock ticks after the previous accepted edge sets flag bit 1. An edge 4 or more ticks later, and past the delay window, sets nothing.
- R4: With `dual_phase` low, an edge that comes before the last channel slot of the frame has started sets flag bit 1. The last slot has index `chan_cnt`-1; a `chan_cnt` of 0 counts as 1. The slots are `word_len` ticks each and start after the delay window. An edge during the last slot or the idle time after it is not an error.
- R5: The edge that causes a framing error is not used as a timing reference. The next edge is accepted unchecked, and the edges after it are checked against it.
- R6: When `TMO_CYC` clock cycles pass with no word-clock edge, flag bit 3 is set.
- R7: Flag bits are: 0 pointer error, 1 word-clock error, 2 bus error, 3 timeout, 4 output-buffer done, 5 input-buffer done. Each event pulse sets its bit on the next clock.
- R8: Bits 0 to 3 are sticky. Only a 1 in the matching `sw_clr` bit clears them, and a clear in the same cycle as a set condition for that bit is ignored.
- R9: Bit 5 is cleared by `in_ptr_wr` and bit 4 by `out_ptr_wr`. A software set of the same bit in that cycle is ignored, but a hardware done event in that cycle still sets the bit.
- R10: A 1 in any `sw_set` bit sets that flag on the next clock unless R9 applies.
- R11: `irq` is high one cycle after any flag bit is high while its `irq_mask` bit is high, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bclk_tick | input | 1 | One-cycle strobe per bit-clock period |
| wclk_edge | input | 1 | One-cycle strobe per word-clock phase edge |
| dual_phase | input | 1 | 1: two-phase frames; 0: single-phase multi-channel frames |
| data_delay | input | DLY_W | Bit-clock ticks between an edge and the first data bit |
| word_len | input | WLEN_W | Bits per channel slot |
| chan_cnt | input | CH_W | Channel slots per single-phase frame |
| ev_ptr_err | input | 1 | Pointer error event pulse |
| ev_bus_err | input | 1 | Bus error event pulse |
| ev_out_done | input | 1 | Output buffer done event pulse |
| ev_in_done | input | 1 | Input buffer done event pulse |
| in_ptr_wr | input | 1 | Input next-pointer written |
| out_ptr_wr | input | 1 | Output next-pointer written |
| sw_set | input | 6 | Software flag set strobes |
| sw_clr | input | 6 | Software flag clear strobes |
| irq_mask | input | 6 | Interrupt enable per flag |
| flags | output | 6 | Raw flag register |
| irq | output | 1 | Registered masked interrupt |

## Verification
The position counters cannot be seen at the ports, so a wrong counter state shows up only at the next word-clock edge. It appears as a flag bit 1 that is missing or false, one clock after that edge. The stimulus therefore places edges one tick on either side of each boundary: the end of the delay window, the 4-tick minimum gap, and the start of the last channel slot. Priority faults in the flag update are visible one clock after the colliding strobes. Faults in the mask path are visible one clock later on `irq`.

// File: rtl/wclk_guard.sv
module wclk_guard #(
  parameter int DLY_W   = 8,
  parameter int WLEN_W  = 5,
  parameter int CH_W    = 4,
  parameter int TMO_CYC = 65535
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bclk_tick,
  input  logic              wclk_edge,
  input  logic              dual_phase,
  input  logic [DLY_W-1:0]  data_delay,
  input  logic [WLEN_W-1:0] word_len,
  input  logic [CH_W-1:0]   chan_cnt,
  input  logic              ev_ptr_err,
  input  logic              ev_bus_err,
  input  logic              ev_out_done,
  input  logic              ev_in_done,
  input  logic              in_ptr_wr,
  input  logic              out_ptr_wr,
  input  logic [5:0]        sw_set,
  input  logic [5:0]        sw_clr,
  input  logic [5:0]        irq_mask,
  output logic [5:0]        flags,
  output logic              irq
);
  localparam int TMO_W   = $clog2(TMO_CYC + 1);
  localparam int MIN_GAP = 4;
  localparam logic [DLY_W-1:0] POS_MAX = '1;
  localparam logic [CH_W-1:0]  CH_MAX  = '1;

  logic [DLY_W-1:0]  pos_q;
  logic [WLEN_W-1:0] wbit_q;
  logic [CH_W-1:0]   chan_q;
  logic              synced_q;
  logic [TMO_W-1:0]  tmo_q;
  logic [5:0]        flags_q, flags_d, hw_set, auto_clr;
  logic              irq_q;

  logic              in_delay, short_gap, early, frame_err, tmo_hit, word_wrap;
  logic [CH_W-1:0]   last_ch;

  assign in_delay  = pos_q < data_delay;
  assign last_ch   = (chan_cnt == '0) ? '0 : chan_cnt - 1'b1;
  assign short_gap = dual_phase && (pos_q < DLY_W'(MIN_GAP));
  assign early     = !dual_phase && (chan_q < last_ch);
  assign frame_err = wclk_edge && synced_q && (in_delay || short_gap || early);
  assign word_wrap = ({1'b0, wbit_q} + 1'b1) >= {1'b0, word_len};
  assign tmo_hit   = !wclk_edge && (tmo_q == TMO_W'(TMO_CYC - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q    <= '0;
      wbit_q   <= '0;
      chan_q   <= '0;
      synced_q <= 1'b0;
    end else if (wclk_edge) begin
      pos_q    <= '0;
      wbit_q   <= '0;
      chan_q   <= '0;
      synced_q <= !frame_err;
    end else if (bclk_tick) begin
      if (pos_q != POS_MAX) pos_q <= pos_q + 1'b1;
      if (!in_delay) begin
        if (word_wrap) begin
          wbit_q <= '0;
          if (chan_q != CH_MAX) chan_q <= chan_q + 1'b1;
        end else begin
          wbit_q <= wbit_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                            tmo_q <= '0;
    else if (wclk_edge)                    tmo_q <= '0;
    else if (tmo_q != TMO_W'(TMO_CYC))     tmo_q <= tmo_q + 1'b1;
  end

  assign hw_set   = {ev_in_done, ev_out_done, tmo_hit, ev_bus_err, frame_err, ev_ptr_err};
  assign auto_clr = {in_ptr_wr, out_ptr_wr, 4'b0000};
  assign flags_d  = hw_set | (~auto_clr & (sw_set | (flags_q & ~sw_clr)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      flags_q <= flags_d;
      irq_q   <= |(flags_q & irq_mask);
    end
  end

  assign flags = flags_q;
  assign irq   = irq_q;
endmodule

module wclk_guard_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wclk_edge,
  input logic       ev_bus_err,
  input logic       ev_in_done,
  input logic       in_ptr_wr,
  input logic [5:0] sw_set,
  input logic [5:0] sw_clr,
  input logic [5:0] irq_mask,
  input logic [5:0] flags,
  input logic       irq
);
  // R8
  sticky_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flags[2]) |-> $past(sw_clr[2]));
  // R8
  sticky_wclk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flags[1]) |-> $past(sw_clr[1]));
  // R8
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_bus_err |=> flags[2]);
  // R9
  auto_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ptr_wr && !ev_in_done) |=> !flags[5]);
  // R2
  frame_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags[1]) |-> ($past(wclk_edge) || $past(sw_set[1])));
  // R6
  timeout_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags[3]) |-> (!$past(wclk_edge) || $past(sw_set[3])));
  // R11
  irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_mask == 6'd0) |=> !irq);
endmodule

bind wclk_guard wclk_guard_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wclk_edge(wclk_edge), .ev_bus_err(ev_bus_err),
  .ev_in_done(ev_in_done), .in_ptr_wr(in_ptr_wr), .sw_set(sw_set),
  .sw_clr(sw_clr), .irq_mask(irq_mask), .flags(flags), .irq(irq)
);

// File: tb/tb_wclk_guard.sv
module tb_wclk_guard;
  localparam int CLK_PERIOD = 10;
  localparam int TMO = 400;
  localparam int NV = 13;
  // {dual, delay[8], word_len[5], chan_cnt[4], ticks[8], expected error}
  localparam logic [26:0] VEC [NV] = '{
    {1'b1, 8'd1, 5'd16, 4'd2, 8'd0,  1'b1},
    {1'b1, 8'd0, 5'd16, 4'd2, 8'd2,  1'b1},
    {1'b1, 8'd0, 5'd16, 4'd2, 8'd4,  1'b0},
    {1'b1, 8'd1, 5'd16, 4'd2, 8'd16, 1'b0},
    {1'b1, 8'd8, 5'd16, 4'd2, 8'd5,  1'b1},
    {1'b1, 8'd8, 5'd16, 4'd2, 8'd8,  1'b0},
    {1'b0, 8'd0, 5'd8,  4'd4, 8'd8,  1'b1},
    {1'b0, 8'd0, 5'd8,  4'd4, 8'd24, 1'b0},
    {1'b0, 8'd0, 5'd8,  4'd4, 8'd30, 1'b0},
    {1'b0, 8'd1, 5'd8,  4'd4, 8'd24, 1'b1},
    {1'b0, 8'd1, 5'd8,  4'd4, 8'd25, 1'b0},
    {1'b0, 8'd2, 5'd4,  4'd1, 8'd1,  1'b1},
    {1'b0, 8'd2, 5'd4,  4'd1, 8'd2,  1'b0}
  };

  logic clk = 0, rst_n = 0, bclk_tick = 0, wclk_edge = 0, dual_phase = 0;
  logic [7:0] data_delay = 0;
  logic [4:0] word_len = 0;
  logic [3:0] chan_cnt = 0;
  logic ev_ptr_err = 0, ev_bus_err = 0, ev_out_done = 0, ev_in_done = 0;
  logic in_ptr_wr = 0, out_ptr_wr = 0;
  logic [5:0] sw_set = 0, sw_clr = 0, irq_mask = 0;
  logic [5:0] flags;
  logic irq;
  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wclk_guard #(.TMO_CYC(TMO)) dut (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0;
    {bclk_tick, wclk_edge, ev_ptr_err, ev_bus_err, ev_out_done, ev_in_done} = '0;
    {in_ptr_wr, out_ptr_wr, sw_set, sw_clr} = '0;
    repeat (2) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      bclk_tick = 1; @(negedge clk);
      bclk_tick = 0; @(negedge clk);
    end
  endtask

  task automatic edge_pulse();
    wclk_edge = 1; @(negedge clk);
    wclk_edge = 0;
  endtask

  // ev = {in_done, out_done, bus_err, ptr_err}
  task automatic cyc(logic [5:0] s, logic [5:0] c, logic ip, logic op, logic [3:0] ev);
    sw_set = s; sw_clr = c; in_ptr_wr = ip; out_ptr_wr = op;
    {ev_in_done, ev_out_done, ev_bus_err, ev_ptr_err} = ev;
    @(negedge clk);
    sw_set = 0; sw_clr = 0; in_ptr_wr = 0; out_ptr_wr = 0;
    {ev_in_done, ev_out_done, ev_bus_err, ev_ptr_err} = '0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1 reset state
    chk("R1 flags", flags, 6'h00);
    chk("R1 irq", irq, 0);

    // R2 R3 R4 framing table
    for (int v = 0; v < NV; v++) begin
      do_reset();
      {dual_phase, data_delay, word_len, chan_cnt} = VEC[v][26:9];
      edge_pulse();
      chk("R1 first edge unchecked", flags, 6'h00);
      ticks(int'(VEC[v][8:1]));
      edge_pulse();
      chk($sformatf("R2/R3/R4 vector %0d", v), flags, {4'b0, VEC[v][0], 1'b0});
    end

    // R5 resync
    do_reset();
    dual_phase = 1; data_delay = 0; word_len = 16; chan_cnt = 2;
    edge_pulse(); ticks(1); edge_pulse();
    chk("R5 error raised", flags, 6'h02);
    cyc(6'h00, 6'h02, 0, 0, 4'h0);
    ticks(1); edge_pulse();
    chk("R5 edge after error unchecked", flags, 6'h00);
    ticks(1); edge_pulse();
    chk("R5 checking resumes", flags, 6'h02);

    // R6 timeout
    do_reset();
    repeat (TMO - 5) @(negedge clk);
    chk("R6 not yet", flags, 6'h00);
    repeat (10) @(negedge clk);
    chk("R6 timeout set", flags, 6'h08);
    edge_pulse();
    chk("R6 sticky across edge", flags, 6'h08);

    // R7 bit order
    do_reset();
    cyc(0, 0, 0, 0, 4'b0001); chk("R7 ptr err bit0", flags, 6'h01);
    cyc(0, 0, 0, 0, 4'b0010); chk("R7 bus err bit2", flags, 6'h05);
    cyc(0, 0, 0, 0, 4'b0100); chk("R7 out done bit4", flags, 6'h15);
    cyc(0, 0, 0, 0, 4'b1000); chk("R7 in done bit5", flags, 6'h35);

    // R8 sticky and set-wins
    cyc(0, 6'h04, 0, 0, 4'b0010); chk("R8 clear vs set", flags, 6'h35);
    cyc(0, 6'h04, 0, 0, 4'h0);    chk("R8 clear bus", flags, 6'h31);
    cyc(0, 6'h01, 0, 0, 4'h0);    chk("R8 clear ptr", flags, 6'h30);

    // R9 auto-clear
    cyc(0, 0, 1, 0, 4'h0);     chk("R9 in ptr write", flags, 6'h10);
    cyc(6'h10, 0, 0, 1, 4'h0); chk("R9 set vs autoclear", flags, 6'h00);
    cyc(0, 0, 1, 0, 4'b1000);  chk("R9 event vs autoclear", flags, 6'h20);
    cyc(0, 6'h20, 0, 0, 4'h0); chk("R9 sw clear bit5", flags, 6'h00);

    // R10 software set
    cyc(6'h0A, 0, 0, 0, 4'h0); chk("R10 sw set", flags, 6'h0A);
    cyc(0, 6'h0A, 0, 0, 4'h0); chk("R10 sw clear", flags, 6'h00);

    // R11 masked interrupt
    irq_mask = 6'h20;
    cyc(0, 0, 0, 0, 4'b1000);
    chk("R11 irq lags flags", irq, 0);
    @(negedge clk); chk("R11 irq high", irq, 1);
    irq_mask = 6'h01;
    @(negedge clk); chk("R11 irq masked off", irq, 0);
    irq_mask = 6'h00;

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule